// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus interface of a byte-wide parallel NOR flash. It watches each qualified bus write (an 18-bit address and a data byte, valid in any cycle where the write strobe is high) and recognises the multi-write unlock sequences. Those sequences request byte programming, whole-array erase, single-sector erase, setting the boot-sector lock, and entering or leaving identification mode. A recognised program or erase is issued to the array and timer back end as a one-cycle command pulse. The pulse carries the operation code, the target address, the data byte and a mask of the sectors affected.

The decoder owns the boot-sector lock bit and enforces it. While the lock is set, a program or sector erase aimed at the boot sector is dropped, and a whole-array erase leaves the boot sector out of its mask. An override input, meant to come from a high-voltage detector, lifts that protection while it is high. Identification mode has its own read port, which returns the manufacturer code, the device code and the lock status. While the back end reports busy, writes are ignored.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock pair (AA to 5555, 55 to 2AAA), then A0 to 5555, then any write (address, data) gives one `cmd_valid` pulse in the cycle after that write. The pulse carries `cmd_op`=1 (program), that address and that data, and `cmd_sectors` set to the target sector.
- R2: An unlock pair then 90 to 5555 sets `id_mode`. While in identification mode, `id_data` returns 1F for read address 0, 08 for address 1, the lock bit on bit 0 for address 2, and 00 for every other address. Outside identification mode `id_data` is 00.
- R3: Identification mode is cleared by an unlock pair then F0 to 5555. It is also cleared by a lone write of F0 to any address when no sequence is in progress.
- R4: An unlock pair, 80 to 5555, a second unlock pair, then 10 to 5555 issues `cmd_op`=2 (chip erase). Its mask is 11111 when unlocked or when the override is high, and 01111 when locked with the override low.
- R5: The same six-write prefix ending in 30 written to any address issues `cmd_op`=3 (sector erase), with exactly one mask bit. The bit is chosen by address: bit 0 for 00000–1FFFF, bit 1 for 20000–37FFF, bit 2 for 38000–39FFF, bit 3 for 3A000–3BFFF, and bit 4 for the boot sector 3C000–3FFFF.
- R6: The six-write prefix ending in 40 to 5555 sets `boot_locked` from the next cycle onward and issues no command. The lock stays set until reset.
- R7: While locked, a program or sector erase whose address lies in the boot sector issues no command if `hv_override` is low. The same request is issued normally if `hv_override` is high.
- R8: Any write that does not match the address and data expected at the current step returns the decoder to idle, so a later partial sequence does not complete.
- R9: Unlock addresses are compared on address bits 14:0 only; bits 17:15 are ignored for those steps.
- R10: A write in a cycle where `busy` is high is ignored. It changes no state, and a sequence in progress continues with the next write taken while not busy.
- R11: Reset clears `cmd_valid`, `id_mode` and `boot_locked`, and abandons any partly entered sequence.
- R12: `cmd_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Qualifies a bus write in this cycle |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Back end is running an operation; writes ignored |
| hv_override | input | 1 | Lifts boot-sector protection while high |
| rd_addr | input | 18 | Read address for the identification port |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| cmd_addr | output | 18 | Command target address |
| cmd_data | output | 8 | Program data byte |
| cmd_sectors | output | 5 | Sectors affected, bit 4 = boot |
| id_mode | output | 1 | Identification mode active |
| id_data | output | 8 | Identification read data |
| boot_locked | output | 1 | Boot-sector lock status |

## Verification
Command outputs, `id_mode` and `boot_locked` all move one clock after the write that completes a sequence is sampled. The bench drives each write on a falling edge, then reads the results on the next falling edge, which is exactly one register stage later. `id_data` is combinational from `rd_addr` and the mode and lock state, so the bench checks it on the same falling edge the state settles. The bench also checks `cmd_valid` on the falling edge after a pulse, to confirm the pulse lasted only one cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int unsigned ADDR_W   = 18;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned UNLOCK_W = 15;
    localparam int unsigned N_SECT   = 5;
    localparam int unsigned BOOT_IDX = N_SECT - 1;

    localparam logic [UNLOCK_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [UNLOCK_W-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [DATA_W-1:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [DATA_W-1:0] KEY_BYTE_B  = 8'h55;
    localparam logic [DATA_W-1:0] OPC_PROGRAM = 8'hA0;
    localparam logic [DATA_W-1:0] OPC_ID_ON   = 8'h90;
    localparam logic [DATA_W-1:0] OPC_ID_OFF  = 8'hF0;
    localparam logic [DATA_W-1:0] OPC_EXTEND  = 8'h80;
    localparam logic [DATA_W-1:0] OPC_CHIP    = 8'h10;
    localparam logic [DATA_W-1:0] OPC_SECTOR  = 8'h30;
    localparam logic [DATA_W-1:0] OPC_LOCK    = 8'h40;

    localparam logic [ADDR_W-1:0] BASE_BOOT  = 18'h3C000;
    localparam logic [ADDR_W-1:0] BASE_PARA1 = 18'h3A000;
    localparam logic [ADDR_W-1:0] BASE_PARA2 = 18'h38000;
    localparam logic [ADDR_W-1:0] BASE_MAIN1 = 18'h20000;

    typedef enum logic [1:0] {
        OP_NONE         = 2'd0,
        OP_PROGRAM      = 2'd1,
        OP_CHIP_ERASE   = 2'd2,
        OP_SECTOR_ERASE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_PROG,
        S_EXT,
        S_EXT_KEY1,
        S_EXT_KEY2
    } seq_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_PROG,
        EV_CHIP,
        EV_SECT,
        EV_LOCK
    } ev_e;

    typedef struct packed {
        ev_e               kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } event_t;

    typedef struct packed {
        op_e               op;
        logic [N_SECT-1:0] sectors;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic [N_SECT-1:0] sector_of(input logic [ADDR_W-1:0] a);
        logic [N_SECT-1:0] m;
        if (a >= BASE_BOOT)       m = 5'b10000;
        else if (a >= BASE_PARA1) m = 5'b01000;
        else if (a >= BASE_PARA2) m = 5'b00100;
        else if (a >= BASE_MAIN1) m = 5'b00010;
        else                      m = 5'b00001;
        return m;
    endfunction

    function automatic logic key_match(input logic [ADDR_W-1:0] a,
                                       input logic [DATA_W-1:0] d,
                                       input logic [UNLOCK_W-1:0] ka,
                                       input logic [DATA_W-1:0] kd);
        return (a[UNLOCK_W-1:0] == ka) && (d == kd);
    endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output event_t            ev,
    output logic              id_mode
);

    seq_e state_q, state_d;
    logic id_d;
    logic take;
    logic at_a;

    assign take = wr_en && !busy;
    assign at_a = (wr_addr[UNLOCK_W-1:0] == KEY_ADDR_A);

    always_comb begin
        state_d = state_q;
        id_d    = id_mode;
        ev      = '{kind: EV_NONE, addr: wr_addr, data: wr_data};
        if (take) begin
            case (state_q)
                S_IDLE: begin
                    if (key_match(wr_addr, wr_data, KEY_ADDR_A, KEY_BYTE_A))
                        state_d = S_KEY1;
                    else if (wr_data == OPC_ID_OFF)
                        id_d = 1'b0;
                end
                S_KEY1:
                    state_d = key_match(wr_addr, wr_data, KEY_ADDR_B, KEY_BYTE_B) ? S_KEY2 : S_IDLE;
                S_KEY2: begin
                    state_d = S_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            OPC_PROGRAM: state_d = S_PROG;
                            OPC_EXTEND:  state_d = S_EXT;
                            OPC_ID_ON:   id_d = 1'b1;
                            OPC_ID_OFF:  id_d = 1'b0;
                            default:     state_d = S_IDLE;
                        endcase
                    end
                end
                S_PROG: begin
                    state_d = S_IDLE;
                    ev.kind = EV_PROG;
                end
                S_EXT:
                    state_d = key_match(wr_addr, wr_data, KEY_ADDR_A, KEY_BYTE_A) ? S_EXT_KEY1 : S_IDLE;
                S_EXT_KEY1:
                    state_d = key_match(wr_addr, wr_data, KEY_ADDR_B, KEY_BYTE_B) ? S_EXT_KEY2 : S_IDLE;
                S_EXT_KEY2: begin
                    state_d = S_IDLE;
                    if (wr_data == OPC_SECTOR)
                        ev.kind = EV_SECT;
                    else if (at_a && wr_data == OPC_CHIP)
                        ev.kind = EV_CHIP;
                    else if (at_a && wr_data == OPC_LOCK)
                        ev.kind = EV_LOCK;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            id_mode <= 1'b0;
        end else begin
            state_q <= state_d;
            id_mode <= id_d;
        end
    end

endmodule

// File: rtl/fcd_guard.sv
module fcd_guard
    import flash_cmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  event_t ev,
    input  logic   hv_override,
    output logic   cmd_valid,
    output cmd_t   cmd,
    output logic   boot_locked
);

    logic              valid_d;
    cmd_t              cmd_d;
    logic              lock_d;
    logic [N_SECT-1:0] tgt;
    logic              boot_hit;
    logic              boot_open;
    logic [N_SECT-1:0] all_mask;

    assign tgt       = sector_of(ev.addr);
    assign boot_hit  = tgt[BOOT_IDX];
    assign boot_open = !boot_locked || hv_override;
    assign all_mask  = '1;

    always_comb begin
        valid_d = 1'b0;
        lock_d  = boot_locked;
        cmd_d   = '{op: OP_NONE, sectors: tgt, addr: ev.addr, data: ev.data};
        case (ev.kind)
            EV_PROG: begin
                if (!boot_hit || boot_open) begin
                    valid_d  = 1'b1;
                    cmd_d.op = OP_PROGRAM;
                end
            end
            EV_SECT: begin
                if (!boot_hit || boot_open) begin
                    valid_d  = 1'b1;
                    cmd_d.op = OP_SECTOR_ERASE;
                end
            end
            EV_CHIP: begin
                valid_d       = 1'b1;
                cmd_d.op      = OP_CHIP_ERASE;
                cmd_d.sectors = all_mask;
                if (!boot_open)
                    cmd_d.sectors[BOOT_IDX] = 1'b0;
            end
            EV_LOCK: lock_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid   <= 1'b0;
            cmd         <= '{op: OP_NONE, sectors: '0, addr: '0, data: '0};
            boot_locked <= 1'b0;
        end else begin
            cmd_valid   <= valid_d;
            cmd         <= cmd_d;
            boot_locked <= lock_d;
        end
    end

endmodule

// File: rtl/fcd_id_port.sv
module fcd_id_port
    import flash_cmd_pkg::*;
#(
    parameter logic [DATA_W-1:0] MFR_CODE = 8'h1F,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h08
) (
    input  logic              id_mode,
    input  logic              boot_locked,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] id_data
);

    always_comb begin
        id_data = '0;
        if (id_mode) begin
            case (rd_addr)
                18'd0:   id_data = MFR_CODE;
                18'd1:   id_data = DEV_CODE;
                18'd2:   id_data = {{(DATA_W-1){1'b0}}, boot_locked};
                default: id_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter logic [7:0] MFR_CODE = 8'h1F,
    parameter logic [7:0] DEV_CODE = 8'h08
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [17:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        busy,
    input  logic        hv_override,
    input  logic [17:0] rd_addr,
    output logic        cmd_valid,
    output logic [1:0]  cmd_op,
    output logic [17:0] cmd_addr,
    output logic [7:0]  cmd_data,
    output logic [4:0]  cmd_sectors,
    output logic        id_mode,
    output logic [7:0]  id_data,
    output logic        boot_locked
);

    event_t ev;
    cmd_t   cmd;

    fcd_seq_fsm i_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .busy    (busy),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ev      (ev),
        .id_mode (id_mode)
    );

    fcd_guard i_guard (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .hv_override (hv_override),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .boot_locked (boot_locked)
    );

    fcd_id_port #(
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) i_id (
        .id_mode     (id_mode),
        .boot_locked (boot_locked),
        .rd_addr     (rd_addr),
        .id_data     (id_data)
    );

    assign cmd_op      = cmd.op;
    assign cmd_addr    = cmd.addr;
    assign cmd_data    = cmd.data;
    assign cmd_sectors = cmd.sectors;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [17:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic        busy,
    input logic        hv_override,
    input logic [17:0] rd_addr,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic [17:0] cmd_addr,
    input logic [7:0]  cmd_data,
    input logic [4:0]  cmd_sectors,
    input logic        id_mode,
    input logic [7:0]  id_data,
    input logic        boot_locked
);

    p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    p_busy_no_cmd_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !cmd_valid);

    p_busy_holds_state_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(id_mode) && $stable(boot_locked)));

    p_chip_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |-> (cmd_sectors[3:0] == 4'hF));

    p_sector_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd3) |-> ($countones(cmd_sectors) == 1));

    p_boot_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 2'd1 || cmd_op == 2'd3) && cmd_sectors[4])
            |-> (!$past(boot_locked) || $past(hv_override)));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        boot_locked |=> boot_locked);

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !id_mode && !boot_locked));

    p_id_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !id_mode |-> (id_data == 8'h00));

endmodule

bind flash_cmd_decoder fcd_checker i_chk (.*);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        hv_override = 1'b0;
    logic [17:0] rd_addr = '0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [17:0] cmd_addr;
    logic [7:0]  cmd_data;
    logic [4:0]  cmd_sectors;
    logic        id_mode;
    logic [7:0]  id_data;
    logic        boot_locked;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic        g_valid;
    logic [1:0]  g_op;
    logic [17:0] g_addr;
    logic [7:0]  g_data;
    logic [4:0]  g_sect;

    bit m_lock = 0;
    bit m_id = 0;

    always #5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_sect(input logic [17:0] a);
        if (a[17:14] == 4'hF)          return 5'b10000;
        else if (a[17:13] == 5'b11101) return 5'b01000;
        else if (a[17:13] == 5'b11100) return 5'b00100;
        else if (a[17])                return 5'b00010;
        else                           return 5'b00001;
    endfunction

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
        g_valid = cmd_valid;
        g_op    = cmd_op;
        g_addr  = cmd_addr;
        g_data  = cmd_data;
        g_sect  = cmd_sectors;
    endtask

    task automatic keys();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic do_prog(input logic [17:0] a, input logic [7:0] d);
        keys();
        wr(18'h05555, 8'hA0);
        wr(a, d);
    endtask

    task automatic do_ext(input logic [17:0] a, input logic [7:0] d);
        keys();
        wr(18'h05555, 8'h80);
        keys();
        wr(a, d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_lock = 0;
        m_id = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        summary();
    end

    initial begin
        logic [31:0] seed_sink;
        seed_sink = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(!cmd_valid && !id_mode && !boot_locked && id_data == 0, "R11 reset state",
            {cmd_valid, id_mode, boot_locked}, 0);

        // R1 basic program
        do_prog(18'h12345, 8'h5A);
        chk(g_valid && g_op == 2'd1 && g_addr == 18'h12345 && g_data == 8'h5A && g_sect == 5'b00001,
            "R1 program", {g_valid, g_op, g_sect, g_data}, {1'b1, 2'd1, 5'b00001, 8'h5A});
        @(negedge clk);
        chk(!cmd_valid, "R12 pulse width", cmd_valid, 0);

        // R9 upper address bits ignored for unlock steps
        wr(18'h1D555, 8'hAA);
        wr(18'h2AAAA, 8'h55);
        wr(18'h3D555, 8'hA0);
        wr(18'h20010, 8'hC3);
        chk(g_valid && g_op == 2'd1 && g_addr == 18'h20010 && g_sect == 5'b00010,
            "R9 aliased unlock", {g_valid, g_op, g_sect}, {1'b1, 2'd1, 5'b00010});

        // R8 mismatch returns to idle
        wr(18'h05555, 8'hAA);
        wr(18'h02AAB, 8'h55);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'hA0);
        wr(18'h00100, 8'h00);
        chk(!g_valid, "R8 broken sequence", g_valid, 0);

        // R2 identification reads
        keys();
        wr(18'h05555, 8'h90);
        chk(id_mode, "R2 id entry", id_mode, 1);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            rd_addr = 18'(i);
            #1;
            e = (i == 0) ? 8'h1F : (i == 1) ? 8'h08 : 8'h00;
            chk(id_data == e, "R2 id read", id_data, e);
        end

        // R3 lone F0 exit, then three-write exit
        wr(18'h00777, 8'hF0);
        chk(!id_mode, "R3 single exit", id_mode, 0);
        rd_addr = 18'd0;
        #1;
        chk(id_data == 8'h00, "R2 quiet outside id", id_data, 0);
        keys();
        wr(18'h05555, 8'h90);
        keys();
        wr(18'h05555, 8'hF0);
        chk(!id_mode, "R3 sequence exit", id_mode, 0);

        // R5 sector erase on each sector
        begin
            logic [17:0] sa [5] = '{18'h00100, 18'h25000, 18'h38800, 18'h3A010, 18'h3C000};
            for (int i = 0; i < 5; i++) begin
                do_ext(sa[i], 8'h30);
                chk(g_valid && g_op == 2'd3 && g_sect == (5'b1 << i) && g_addr == sa[i],
                    "R5 sector erase", {g_valid, g_op, g_sect}, {1'b1, 2'd3, 5'b1 << i});
            end
        end

        // R4 chip erase unlocked
        do_ext(18'h05555, 8'h10);
        chk(g_valid && g_op == 2'd2 && g_sect == 5'b11111, "R4 chip erase open",
            {g_valid, g_op, g_sect}, {1'b1, 2'd2, 5'b11111});

        // R6 lock enable
        do_ext(18'h05555, 8'h40);
        chk(!g_valid && boot_locked, "R6 lock enable", {g_valid, boot_locked}, 1);
        keys();
        wr(18'h05555, 8'h90);
        rd_addr = 18'd2;
        #1;
        chk(id_data == 8'h01, "R2 lock status read", id_data, 8'h01);
        wr(18'h00000, 8'hF0);

        // R7 boot protection
        do_prog(18'h3C123, 8'h11);
        chk(!g_valid, "R7 locked program", g_valid, 0);
        do_ext(18'h3FFFF, 8'h30);
        chk(!g_valid, "R7 locked sector erase", g_valid, 0);
        do_prog(18'h10000, 8'h22);
        chk(g_valid && g_op == 2'd1, "R7 non-boot program while locked", g_valid, 1);
        hv_override = 1'b1;
        do_prog(18'h3C123, 8'h11);
        chk(g_valid && g_op == 2'd1 && g_sect == 5'b10000, "R7 override program",
            {g_valid, g_sect}, {1'b1, 5'b10000});

        // R4 chip erase locked, with and without override
        do_ext(18'h05555, 8'h10);
        chk(g_valid && g_sect == 5'b11111, "R4 chip erase override", g_sect, 5'b11111);
        hv_override = 1'b0;
        do_ext(18'h05555, 8'h10);
        chk(g_valid && g_op == 2'd2 && g_sect == 5'b01111, "R4 chip erase locked",
            g_sect, 5'b01111);

        // R10 busy ignores writes, sequence continues
        keys();
        wr(18'h05555, 8'hA0);
        busy = 1'b1;
        wr(18'h00100, 8'h33);
        chk(!g_valid, "R10 busy write dropped", g_valid, 0);
        busy = 1'b0;
        wr(18'h00200, 8'h44);
        chk(g_valid && g_addr == 18'h00200 && g_data == 8'h44, "R10 sequence resumes",
            {g_addr, g_data}, {18'h00200, 8'h44});
        keys();
        wr(18'h05555, 8'h90);
        busy = 1'b1;
        wr(18'h00000, 8'hF0);
        chk(id_mode, "R10 busy keeps id mode", id_mode, 1);
        busy = 1'b0;
        wr(18'h00000, 8'hF0);

        // R11 reset mid-sequence
        keys();
        wr(18'h05555, 8'hA0);
        do_reset();
        chk(!boot_locked && !cmd_valid, "R11 reset clears lock", boot_locked, 0);
        wr(18'h00300, 8'h55);
        chk(!g_valid, "R11 sequence abandoned", g_valid, 0);

        // Constrained random mix against the bench model
        for (int it = 0; it < 300; it++) begin
            int k;
            logic [17:0] a;
            logic [7:0] d;
            bit open;
            k = int'($urandom % 7);
            a = 18'($urandom);
            d = 8'($urandom);
            hv_override = (($urandom % 4) == 0);
            open = !m_lock || hv_override;
            case (k)
                0: begin
                    do_prog(a, d);
                    chk(g_valid == (ref_sect(a) != 5'b10000 || open) &&
                        (!g_valid || (g_op == 2'd1 && g_addr == a && g_data == d && g_sect == ref_sect(a))),
                        "R1/R7 random program", {g_valid, g_sect}, {open, ref_sect(a)});
                end
                1: begin
                    do_ext(a, 8'h30);
                    chk(g_valid == (ref_sect(a) != 5'b10000 || open) &&
                        (!g_valid || (g_op == 2'd3 && g_sect == ref_sect(a))),
                        "R5/R7 random sector erase", {g_valid, g_sect}, {open, ref_sect(a)});
                end
                2: begin
                    do_ext(18'h05555, 8'h10);
                    chk(g_valid && g_sect == (open ? 5'b11111 : 5'b01111),
                        "R4 random chip erase", g_sect, open ? 5'b11111 : 5'b01111);
                end
                3: begin
                    do_ext(18'h05555, 8'h40);
                    m_lock = 1;
                    chk(!g_valid && boot_locked, "R6 random lock", {g_valid, boot_locked}, 1);
                end
                4: begin
                    keys();
                    wr(18'h05555, 8'h90);
                    m_id = 1;
                    rd_addr = 18'($urandom % 4);
                    #1;
                    begin
                        logic [7:0] e;
                        e = (rd_addr == 0) ? 8'h1F : (rd_addr == 1) ? 8'h08 :
                            (rd_addr == 2) ? {7'b0, m_lock} : 8'h00;
                        chk(id_mode && id_data == e, "R2 random id read", id_data, e);
                    end
                end
                5: begin
                    if (d == 8'hAA) d = 8'h11;
                    wr(a, d);
                    if (d == 8'hF0) m_id = 0;
                    chk(!g_valid && id_mode == m_id, "R3/R8 random stray write",
                        {g_valid, id_mode}, {1'b0, m_id});
                end
                default: begin
                    if (($urandom % 3) == 0) begin
                        do_reset();
                        chk(!id_mode && !boot_locked, "R11 random reset", {id_mode, boot_locked}, 0);
                    end else begin
                        keys();
                        wr(18'h05555, 8'hF0);
                        m_id = 0;
                        chk(!id_mode, "R3 random exit", id_mode, 0);
                    end
                end
            endcase
        end

        summary();
    end

endmodule